// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC. It picks up the first six bytes of each frame, which form the destination address, and gives one accept or drop verdict per frame. The verdict comes from a table of 17 programmable 48-bit entries, each with its own enable bit. A promiscuous input bypasses the table and accepts every frame.

Software programs the table through 32-bit word writes, two words per entry. The usual fill order starts at entry 0 with broadcast, then the station address, then multicast groups. When more groups are needed than the table can hold, software sets promiscuous mode instead.

The table, the enable mask and the promiscuous input are frozen at the start of each frame. Any change made while a frame is in flight applies to the following frame.

Top module: `da_filter`

## Requirements
- R1: After reset, dec_valid_o and accept_o are 0, and all entries and enable bits are 0.
- R2: Word address 2*i writes entry i bytes 0 and 1 from wr_data_i[15:8] and [7:0]. Word address 2*i+1 writes bytes 2, 3, 4 and 5 from wr_data_i[31:24] down to [7:0]. Byte 0 is the first byte received.
- R3: Word address 34 writes the enable mask from wr_data_i[16:0]. Entry i is enabled by bit 16-i. A disabled entry never causes an accept.
- R4: If prom_i is 1 in the start-of-frame beat, the frame is accepted, whatever the table and mask hold (an all-zero mask included).
- R5: With promiscuous off, a frame of six or more bytes is accepted exactly when its first six bytes equal an enabled entry.
- R6: dec_valid_o and accept_o take their verdict at the clock edge that captures the sixth byte. After that they hold until the next start-of-frame beat.
- R7: A frame whose end beat (in_eof_i) comes before the sixth byte gets its verdict at that edge. The verdict is a drop when promiscuous is off and an accept when it is on.
- R8: Writes and prom_i changes made during a frame, including in its start-of-frame beat, affect only later frames.
- R9: A start-of-frame beat that is not also an end beat clears dec_valid_o at that edge.
- R10: Writes to word addresses 35 to 63 change no entry and no enable bit.
- R11: Bytes after the sixth do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| prom_i | input | 1 | Promiscuous mode, sampled at start of frame |
| in_valid_i | input | 1 | A byte is present this cycle |
| in_sof_i | input | 1 | This byte is the first byte of a frame |
| in_eof_i | input | 1 | This byte is the last byte of a frame |
| in_data_i | input | 8 | Received byte |
| dec_valid_o | output | 1 | The verdict for the current frame is available |
| accept_o | output | 1 | Verdict: 1 accepts the frame, 0 drops it |

## Verification
A register write can land in the same cycle as a frame's start-of-frame beat, and also on any later beat of that frame. The bench issues entry, mask and prom_i changes in the start beat and in mid-frame beats. It expects the verdict computed from the table as it stood before the write, and then expects the next frame to see the new contents. Random frames mix table hits, misses, disabled entries, short frames and random promiscuous settings. These are checked against a bench model of the table.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int unsigned MAC_W   = 48;
  localparam int unsigned DA_BYTES = MAC_W / 8;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/dmf_cfg.sv
module dmf_cfg
  import dmf_pkg::*;
#(
  parameter int NUM_ENT = 17,
  parameter int WA_W    = $clog2(2*NUM_ENT+1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [WA_W-1:0]               wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic                          load_i,
  output logic [NUM_ENT-1:0][MAC_W-1:0] act_tab_o,
  output logic [NUM_ENT-1:0]            act_en_o
);
  localparam int EN_WORD = 2*NUM_ENT;

  logic [NUM_ENT-1:0][MAC_W-1:0] prog_q, act_q;
  logic [NUM_ENT-1:0]            prog_en_q, act_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q    <= '0;
      act_q     <= '0;
      prog_en_q <= '0;
      act_en_q  <= '0;
    end else begin
      if (wr_en_i) begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (wr_addr_i == WA_W'(2*i))   prog_q[i][MAC_W-1:32] <= wr_data_i[15:0];
          if (wr_addr_i == WA_W'(2*i+1)) prog_q[i][31:0]       <= wr_data_i;
        end
        if (wr_addr_i == WA_W'(EN_WORD)) prog_en_q <= wr_data_i[NUM_ENT-1:0];
      end
      // snapshot takes pre-write values when a write shares the SOF beat
      if (load_i) begin
        act_q    <= prog_q;
        act_en_q <= prog_en_q;
      end
    end
  end

  assign act_tab_o = act_q;
  assign act_en_o  = act_en_q;
endmodule

// File: rtl/dmf_match.sv
module dmf_match
  import dmf_pkg::*;
#(
  parameter int NUM_ENT = 17
) (
  input  mac_t                          addr_i,
  input  logic [NUM_ENT-1:0][MAC_W-1:0] tab_i,
  input  logic [NUM_ENT-1:0]            en_i,
  output logic                          hit_o
);
  logic [NUM_ENT-1:0] hit_vec;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    // entry 0 owns the top enable bit
    assign hit_vec[i] = en_i[NUM_ENT-1-i] && (tab_i[i] == addr_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/dmf_frame.sv
module dmf_frame
  import dmf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prom_i,
  input  logic       in_valid_i,
  input  logic       in_sof_i,
  input  logic       in_eof_i,
  input  logic [7:0] in_data_i,
  input  logic       hit_i,
  output mac_t       cand_addr_o,
  output logic       load_o,
  output logic       dec_valid_o,
  output logic       accept_o
);
  localparam int CNT_W = $clog2(DA_BYTES+1);
  localparam int SH_W  = MAC_W - 8;

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  logic             prom_q;
  logic             collect;

  assign collect     = in_valid_i && !in_sof_i && (cnt_q != '0) && (cnt_q < CNT_W'(DA_BYTES));
  assign cand_addr_o = {sh_q, in_data_i};
  assign load_o      = in_valid_i && in_sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      prom_q      <= 1'b0;
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
    end else if (load_o) begin
      cnt_q       <= in_eof_i ? '0 : CNT_W'(1);
      sh_q        <= {{(SH_W-8){1'b0}}, in_data_i};
      prom_q      <= prom_i;
      dec_valid_o <= in_eof_i;
      accept_o    <= in_eof_i && prom_i;
    end else if (collect) begin
      sh_q <= {sh_q[SH_W-9:0], in_data_i};
      if (cnt_q == CNT_W'(DA_BYTES-1)) begin
        cnt_q       <= CNT_W'(DA_BYTES);
        dec_valid_o <= 1'b1;
        accept_o    <= prom_q || hit_i;
      end else if (in_eof_i) begin
        cnt_q       <= '0;
        dec_valid_o <= 1'b1;
        accept_o    <= prom_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !(in_valid_i && in_sof_i) |=> dec_valid_o && $stable(accept_o));

  p_sixth_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_sof_i && (cnt_q == CNT_W'(DA_BYTES-1)) |=> dec_valid_o);

  p_sof_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_sof_i && !in_eof_i |=> !dec_valid_o);

  p_short_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_sof_i && in_eof_i && !prom_q && (cnt_q != '0)
      && (cnt_q < CNT_W'(DA_BYTES-1)) |=> dec_valid_o && !accept_o);

  p_prom_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && prom_q |-> accept_o);
endmodule

// File: rtl/da_filter.sv
module da_filter
  import dmf_pkg::*;
#(
  parameter int NUM_ENT = 17,
  parameter int WA_W    = $clog2(2*NUM_ENT+1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WA_W-1:0] wr_addr_i,
  input  logic [31:0]     wr_data_i,
  input  logic            prom_i,
  input  logic            in_valid_i,
  input  logic            in_sof_i,
  input  logic            in_eof_i,
  input  logic [7:0]      in_data_i,
  output logic            dec_valid_o,
  output logic            accept_o
);
  logic [NUM_ENT-1:0][MAC_W-1:0] act_tab;
  logic [NUM_ENT-1:0]            act_en;
  mac_t                          cand_addr;
  logic                          load, hit;

  dmf_cfg #(.NUM_ENT(NUM_ENT), .WA_W(WA_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .act_tab_o(act_tab), .act_en_o(act_en)
  );

  dmf_match #(.NUM_ENT(NUM_ENT)) u_match (
    .addr_i(cand_addr), .tab_i(act_tab), .en_i(act_en), .hit_o(hit)
  );

  dmf_frame u_frame (
    .clk_i, .rst_ni, .prom_i, .in_valid_i, .in_sof_i, .in_eof_i, .in_data_i,
    .hit_i(hit), .cand_addr_o(cand_addr), .load_o(load),
    .dec_valid_o, .accept_o
  );

  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !dec_valid_o);
endmodule

// File: tb/da_filter_tb.sv
module da_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 17;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, prom = 0, in_valid = 0, in_sof = 0, in_eof = 0;
  logic [5:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0] in_data = 0;
  logic dec_valid, accept;

  int n_chk = 0, n_fail = 0;
  logic [47:0] m_tab [NE];
  logic [NE-1:0] m_en = '0;
  bit mid_en = 0; int mid_at = 0; logic [5:0] mid_addr; logic [31:0] mid_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .prom_i(prom), .in_valid_i(in_valid), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .in_data_i(in_data), .dec_valid_o(dec_valid), .accept_o(accept)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [5:0] a, input logic [31:0] d);
    if (a < 6'(2*NE)) begin
      if (a[0]) m_tab[a/2][31:0] = d;
      else      m_tab[a/2][47:32] = d[15:0];
    end else if (a == 6'(2*NE)) m_en = d[NE-1:0];
  endfunction

  function automatic bit exp_acc(input logic [47:0] dst, input bit pr, input int len);
    if (pr) return 1;
    if (len < 6) return 0;
    for (int i = 0; i < NE; i++)
      if (m_en[NE-1-i] && m_tab[i] == dst) return 1;
    return 0;
  endfunction

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic set_ent(input int i, input logic [47:0] mac);
    wr_reg(6'(2*i), {16'h0, mac[47:32]});
    wr_reg(6'(2*i+1), mac[31:0]);
  endtask

  task automatic run_frame(input logic [47:0] dst, input int len, input bit pr, input string tag);
    bit e; int chk_at;
    e = exp_acc(dst, pr, len);
    chk_at = (len < 6) ? len : 6;
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      if (k == 1 && len > 1) chk(dec_valid == 0, "R9 sof clears", 64'(dec_valid), 0);
      if (k == chk_at) begin
        chk(dec_valid == 1, {tag, " valid"}, 64'(dec_valid), 1);
        chk(accept == e, {tag, " verdict"}, 64'(accept), 64'(e));
      end
      wr_en = 0;
      if (mid_en && k == mid_at) begin wr_en = 1; wr_addr = mid_addr; wr_data = mid_data; end
      if (k < len) begin
        in_valid = 1; in_sof = (k == 0); in_eof = (k == len-1);
        in_data = (k < 6) ? dst[47-8*k -: 8] : 8'($urandom);
        prom = (k == 0) ? pr : 1'($urandom);
      end else begin
        in_valid = 0; in_sof = 0; in_eof = 0;
      end
    end
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    chk(dec_valid == 1 && accept == e, "R11 verdict held", {dec_valid, accept}, {1'b1, e});
    if (mid_en) model_wr(mid_addr, mid_data);
    mid_en = 0;
  endtask

  logic [47:0] bc = 48'hFFFF_FFFF_FFFF, sta = 48'h0250_C2A1_B3C4, mc = 48'h0100_5E00_0001;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) m_tab[i] = '0;
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && accept == 0, "R1 reset outputs", {dec_valid, accept}, 0);
    rst_n = 1;
    // R1: table empty, promiscuous off -> drop
    run_frame(bc, 8, 0, "R1 empty table");
    set_ent(0, bc); set_ent(1, sta); set_ent(2, mc); set_ent(3, mc + 1); set_ent(4, mc + 2);
    wr_reg(6'd34, 32'h0001_F000);
    run_frame(bc, 10, 0, "R5 broadcast");
    run_frame(sta, 6, 0, "R2 station layout");
    run_frame(mc + 2, 12, 0, "R5 multicast");
    run_frame(48'h0250_C2A1_B3C5, 9, 0, "R5 miss");
    set_ent(5, 48'h3333_0000_00FB);
    run_frame(48'h3333_0000_00FB, 8, 0, "R3 disabled entry");
    wr_reg(6'd34, 32'h0000_0800);
    run_frame(48'h3333_0000_00FB, 8, 0, "R3 bit 16-i enable");
    run_frame(bc, 8, 0, "R3 entry0 now disabled");
    set_ent(16, 48'hA1A2_A3A4_A5A6);
    wr_reg(6'd34, 32'h0000_0001);
    run_frame(48'hA1A2_A3A4_A5A6, 7, 0, "R3 last entry bit 0");
    wr_reg(6'd34, 32'h0);
    run_frame(48'h1234_5678_9ABC, 8, 1, "R4 prom empty mask");
    run_frame(48'h1234_5678_9ABC, 8, 0, "R4 prom off");
    run_frame(bc, 3, 0, "R7 short drop");
    run_frame(bc, 1, 1, "R7 one-byte prom");
    run_frame(bc, 5, 1, "R7 short prom");
    // R8: mid-frame enable write
    mid_en = 1; mid_at = 3; mid_addr = 6'd34; mid_data = 32'h0001_F800;
    run_frame(bc, 8, 0, "R8 mid-frame write");
    run_frame(bc, 8, 0, "R8 next frame");
    // R8: write in the SOF beat
    mid_en = 1; mid_at = 0; mid_addr = 6'd1; mid_data = 32'h0000_ABCD;
    run_frame(sta, 8, 0, "R8 sof-cycle write");
    run_frame(sta, 8, 0, "R8 after sof write");
    // R10: unmapped addresses
    for (int a = 35; a < 64; a++) wr_reg(6'(a), 32'h0);
    run_frame(bc, 8, 0, "R10 unmapped write");
    run_frame(mc, 8, 0, "R10 table intact");
    // random
    for (int n = 0; n < 300; n++) begin
      int idx; logic [47:0] d; int len; bit pr;
      if ($urandom % 8 == 0) wr_reg(6'd34, $urandom);
      if ($urandom % 10 == 0) set_ent($urandom % NE, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
      idx = $urandom % NE;
      d = ($urandom % 2) ? m_tab[idx] : 48'({$urandom, $urandom});
      len = 1 + $urandom % 16;
      pr = ($urandom % 4 == 0);
      if ($urandom % 6 == 0) begin
        mid_en = 1; mid_at = $urandom % (len + 1);
        mid_addr = 6'($urandom % 35); mid_data = $urandom;
      end
      run_frame(d, len, pr, "R5 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule